// File: doc/BRIEF.md
# Triggered Memory DMA Channel

This block is one bus-mastering copy channel. Software first loads a source address, a destination address and a 32-bit control word through a small register port. The control word sets how many units to move, whether each unit is a 16-bit halfword or a 32-bit word, how each address moves after a unit, and what starts the block. A block can start at once, or on the next vertical-blank, horizontal-blank or FIFO-request pulse. It can run once or re-arm itself for every trigger.

While a block runs, the channel owns the memory bus. Each unit takes two bus cycles: a read from the source, then a write of the same data to the destination. The processor is held off by a stall output for the whole block. Both addresses have their low bits cleared to match the unit size when they are loaded, so every bus access is aligned. Writing a control word with the enable bit clear stops the channel at once, whether it is moving data or waiting for a trigger.

Working copies of the addresses are taken when the control word is written with the enable bit set. In repeat mode the count is reloaded on every trigger, while the addresses carry on from where the previous block stopped.

Top module: `trig_dma_channel`

## Requirements
- R1: After reset, `cpu_stall` and `mem_req` are low and all three registers (address 0 source, 1 destination, 2 control) read back as zero.
- R2: A control write with bit 31 set and start field bits 29:28 = 00 begins the block in the next cycle. Each unit is one read cycle (`mem_we`=0 at the source address) followed by one write cycle (`mem_we`=1 at the destination address) carrying the data that was read.
- R3: Control bit 26 selects the unit: 1 = 32-bit word, with addresses stepping by 4 and `mem_word`=1; 0 = halfword, with addresses stepping by 2 and `mem_word`=0.
- R4: The destination step mode in control bits 22:21 is 00 = increment, 01 = decrement, 10 = fixed. Code 11 also holds the address fixed.
- R5: The source step mode in control bits 24:23 uses the same codes as R4.
- R6: When the addresses are loaded, the channel clears the low two address bits for word units and the low bit for halfword units.
- R7: Start field 01 waits for `vblank_pulse`, 10 for `hblank_pulse` and 11 for `fifo_req_pulse`. While the channel is armed, a pulse of any other kind starts nothing.
- R8: Without repeat (bit 25 = 0), control bit 31 reads back as 0 once the block has ended.
- R9: With repeat (bit 25 = 1) and a triggered start, bit 31 stays set after a block. The next matching trigger moves a fresh block of the programmed count, continuing from the addresses where the previous block stopped.
- R10: A control write with bit 31 clear cancels an armed channel. Later triggers then cause no bus activity.
- R11: A count field (control bits 15:0) of zero moves 65536 units.
- R12: `cpu_stall` is high for exactly 2 cycles per unit of a block and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select: 0 source, 1 destination, 2 control |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data for `cpu_addr` |
| cpu_stall | output | 1 | Processor hold-off while the channel owns the bus |
| vblank_pulse | input | 1 | Vertical-blank trigger |
| hblank_pulse | input | 1 | Horizontal-blank trigger |
| fifo_req_pulse | input | 1 | FIFO-request trigger |
| mem_req | output | 1 | Bus cycle valid |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | 32 | Bus byte address |
| mem_word | output | 1 | 1 = 32-bit access, 0 = 16-bit access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the read cycle (zero wait) |

## Verification
Immediate blocks are run with three combinations of step mode and unit size: incrementing words, a decrementing halfword source into a fixed halfword destination, and a fixed word source into a decrementing word destination. Misaligned start addresses are used, so any error in step direction, step size or low-bit masking shows up as a wrong bus address. Triggered blocks are armed on one trigger kind and then hit with the other two, to show the start field selects its own pulse. A repeat block is fired twice to tell a count reload from an address reload, then cancelled and triggered again to show that the cancel holds. A zero count run measures the stall length, which separates the maximum-count rule from an empty transfer.

// File: rtl/tdma_pkg.sv
// Package: shared types and control-word field positions for the DMA channel.
// Assumes a 32-bit control word; count field occupies the low CNT_W bits.
package tdma_pkg;

    localparam int CTL_W     = 32;
    localparam int B_ENABLE  = 31;
    localparam int B_START_H = 29;
    localparam int B_START_L = 28;
    localparam int B_WORD    = 26;
    localparam int B_RPT     = 25;
    localparam int B_SSTEP_H = 24;
    localparam int B_SSTEP_L = 23;
    localparam int B_DSTEP_H = 22;
    localparam int B_DSTEP_L = 21;

    typedef enum logic [1:0] {
        STEP_INC = 2'b00,
        STEP_DEC = 2'b01,
        STEP_FIX = 2'b10,
        STEP_RSV = 2'b11
    } step_e;

    typedef enum logic [1:0] {
        GO_NOW  = 2'b00,
        GO_VBL  = 2'b01,
        GO_HBL  = 2'b10,
        GO_FIFO = 2'b11
    } start_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARMED,
        S_RD,
        S_WR
    } chan_state_e;

endpackage

// File: rtl/tdma_regs.sv
// Module: register file of the channel (source, destination, control).
// Assumes writes are single-cycle strobes; a CPU write to control always
// wins over the engine's end-of-block enable clear in the same cycle.
module tdma_regs
    import tdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_wr,
    input  logic [1:0]          cpu_addr,
    input  logic [CTL_W-1:0]    cpu_wdata,
    output logic [CTL_W-1:0]    cpu_rdata,
    input  logic                blk_done,
    output logic [ADDR_W-1:0]   src_q,
    output logic [ADDR_W-1:0]   dst_q,
    output logic                ctl_en,
    output start_e              ctl_start,
    output logic                ctl_word,
    output logic                ctl_rpt,
    output step_e               ctl_sstep,
    output step_e               ctl_dstep,
    output logic [CNT_W-1:0]    ctl_count,
    output logic                wr_start,
    output logic                wr_stop,
    output logic                wr_now,
    output logic                wr_word,
    output logic [CNT_W-1:0]    wr_count
);

    logic [CTL_W-1:0] ctl_raw;
    logic             ctl_hit;

    // Decode a write aimed at the control register.
    always_comb begin
        ctl_hit  = cpu_wr && (cpu_addr == 2'd2);
        wr_start = ctl_hit && cpu_wdata[B_ENABLE];
        wr_stop  = ctl_hit && !cpu_wdata[B_ENABLE];
        wr_now   = (cpu_wdata[B_START_H:B_START_L] == GO_NOW);
        wr_word  = cpu_wdata[B_WORD];
        wr_count = cpu_wdata[CNT_W-1:0];
    end

    // Hold the address registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (cpu_wr) begin
            if (cpu_addr == 2'd0) src_q <= cpu_wdata[ADDR_W-1:0];
            if (cpu_addr == 2'd1) dst_q <= cpu_wdata[ADDR_W-1:0];
        end
    end

    // Hold the control word; the enable bit self-clears at end of a one-shot block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_raw <= '0;
        end else if (ctl_hit) begin
            ctl_raw <= cpu_wdata;
        end else if (blk_done) begin
            ctl_raw[B_ENABLE] <= 1'b0;
        end
    end

    // Split the stored control word into fields.
    always_comb begin
        ctl_en    = ctl_raw[B_ENABLE];
        ctl_start = start_e'(ctl_raw[B_START_H:B_START_L]);
        ctl_word  = ctl_raw[B_WORD];
        ctl_rpt   = ctl_raw[B_RPT];
        ctl_sstep = step_e'(ctl_raw[B_SSTEP_H:B_SSTEP_L]);
        ctl_dstep = step_e'(ctl_raw[B_DSTEP_H:B_DSTEP_L]);
        ctl_count = ctl_raw[CNT_W-1:0];
    end

    // Register read multiplexer.
    always_comb begin
        case (cpu_addr)
            2'd0:    cpu_rdata = CTL_W'(src_q);
            2'd1:    cpu_rdata = CTL_W'(dst_q);
            2'd2:    cpu_rdata = ctl_raw;
            default: cpu_rdata = '0;
        endcase
    end

    // R8: a finished one-shot block leaves the enable bit clear.
    a_r8_enable_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && !cpu_wr) |=> !ctl_raw[B_ENABLE]);

endmodule

// File: rtl/tdma_stepper.sv
// Module: working address of one side (source or destination).
// Loads an aligned copy of the register value and moves it by the unit
// size after each unit according to the step mode. Assumes load and adv
// are never asserted together with differing intent (load wins).
module tdma_stepper
    import tdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              load_word,
    input  logic              adv,
    input  step_e             mode,
    input  logic              unit_word,
    output logic [ADDR_W-1:0] addr_q
);

    localparam logic [ADDR_W-1:0] MASK_W = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] MASK_H = ~ADDR_W'(1);

    logic [ADDR_W-1:0] step_amt;

    // Unit size in bytes.
    always_comb step_amt = unit_word ? ADDR_W'(4) : ADDR_W'(2);

    // Load an aligned address or step it after a unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val & (load_word ? MASK_W : MASK_H);
        end else if (adv) begin
            case (mode)
                STEP_INC: addr_q <= addr_q + step_amt;
                STEP_DEC: addr_q <= addr_q - step_amt;
                default:  addr_q <= addr_q;
            endcase
        end
    end

    // R4/R5: a fixed-mode address does not move across a unit.
    a_r4_r5_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && mode[1]) |=> $stable(addr_q));

endmodule

// File: rtl/tdma_engine.sv
// Module: channel sequencer. Waits for its start condition, then issues one
// read and one write per unit until the count runs out, holding the
// processor off meanwhile. Assumes zero-wait memory (read data valid in
// the read cycle). A count of zero means 2**CNT_W units.
module tdma_engine
    import tdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_stop,
    input  logic              wr_now,
    input  logic [CNT_W-1:0]  wr_count,
    input  logic              ctl_en,
    input  start_e            ctl_start,
    input  logic              ctl_rpt,
    input  logic              ctl_word,
    input  logic [CNT_W-1:0]  ctl_count,
    input  logic              trig_vbl,
    input  logic              trig_hbl,
    input  logic              trig_fifo,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_word,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              cpu_stall,
    output logic              blk_done,
    output logic              src_adv,
    output logic              dst_adv
);

    localparam int CW = CNT_W + 1;

    chan_state_e       state_q;
    logic [CW-1:0]     cnt_q;
    logic [DATA_W-1:0] data_q;
    logic              trig_hit;
    logic              last_unit;
    logic              rearm;

    // Expand a count field, zero meaning the full range.
    function automatic logic [CW-1:0] full_cnt(input logic [CNT_W-1:0] c);
        return (c == '0) ? (CW'(1) << CNT_W) : CW'(c);
    endfunction

    // Match the selected start condition against the trigger pulses.
    always_comb begin
        case (ctl_start)
            GO_VBL:  trig_hit = trig_vbl;
            GO_HBL:  trig_hit = trig_hbl;
            GO_FIFO: trig_hit = trig_fifo;
            default: trig_hit = 1'b0;
        endcase
        trig_hit = trig_hit && ctl_en;
    end

    // End-of-block conditions.
    always_comb begin
        last_unit = (state_q == S_WR) && (cnt_q == CW'(1));
        rearm     = ctl_rpt && (ctl_start != GO_NOW);
        blk_done  = last_unit && !rearm && !wr_start && !wr_stop;
        src_adv   = (state_q == S_RD);
        dst_adv   = (state_q == S_WR);
    end

    // Sequence the channel through armed, read and write states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else if (wr_stop) begin
            state_q <= S_IDLE;
        end else if (wr_start) begin
            state_q <= wr_now ? S_RD : S_ARMED;
            cnt_q   <= full_cnt(wr_count);
        end else begin
            case (state_q)
                S_ARMED: if (trig_hit) begin
                    state_q <= S_RD;
                    cnt_q   <= full_cnt(ctl_count);
                end
                S_RD: state_q <= S_WR;
                S_WR: begin
                    cnt_q <= cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) state_q <= rearm ? S_ARMED : S_IDLE;
                    else                 state_q <= S_RD;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Capture the unit read from the source.
    always_ff @(posedge clk) begin
        if (!rst_n)                data_q <= '0;
        else if (state_q == S_RD)  data_q <= mem_rdata;
    end

    // Drive the bus and the processor hold-off.
    always_comb begin
        mem_req   = (state_q == S_RD) || (state_q == S_WR);
        mem_we    = (state_q == S_WR);
        mem_addr  = mem_we ? dst_addr : src_addr;
        mem_word  = ctl_word;
        mem_wdata = data_q;
        cpu_stall = mem_req;
    end

    // R2: every read cycle is followed by its write cycle.
    a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !wr_start && !wr_stop) |=> (mem_req && mem_we));

    // R10: a disabling control write leaves the bus quiet next cycle.
    a_r10_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stop |=> !mem_req);

    // R7: an armed channel without a matching trigger stays off the bus.
    a_r7_armed_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && !trig_hit && !wr_start) |=> !mem_req);

    // R11: a running block never sees an exhausted count.
    a_r11_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (cnt_q != '0));

endmodule

// File: rtl/trig_dma_channel.sv
// Module: top of the triggered DMA channel. Ties the register file, the
// sequencer and the two address steppers together. Assumes zero-wait
// memory and that no other master contends for the bus.
module trig_dma_channel
    import tdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_stall,
    input  logic              vblank_pulse,
    input  logic              hblank_pulse,
    input  logic              fifo_req_pulse,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_word,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int SIDES = 2;

    logic [ADDR_W-1:0] src_q, dst_q;
    logic              ctl_en, ctl_word, ctl_rpt;
    start_e            ctl_start;
    step_e             ctl_sstep, ctl_dstep;
    logic [CNT_W-1:0]  ctl_count, wr_count;
    logic              wr_start, wr_stop, wr_now, wr_word;
    logic              blk_done, src_adv, dst_adv;

    logic  [SIDES-1:0][ADDR_W-1:0] side_reg;
    logic  [SIDES-1:0][ADDR_W-1:0] side_addr;
    logic  [SIDES-1:0]             side_adv;
    step_e [SIDES-1:0]             side_mode;

    tdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .blk_done(blk_done),
        .src_q(src_q), .dst_q(dst_q),
        .ctl_en(ctl_en), .ctl_start(ctl_start), .ctl_word(ctl_word),
        .ctl_rpt(ctl_rpt), .ctl_sstep(ctl_sstep), .ctl_dstep(ctl_dstep),
        .ctl_count(ctl_count),
        .wr_start(wr_start), .wr_stop(wr_stop), .wr_now(wr_now),
        .wr_word(wr_word), .wr_count(wr_count)
    );

    // Gather per-side inputs: index 0 is the source, 1 the destination.
    always_comb begin
        side_reg[0]  = src_q;
        side_reg[1]  = dst_q;
        side_adv[0]  = src_adv;
        side_adv[1]  = dst_adv;
        side_mode[0] = ctl_sstep;
        side_mode[1] = ctl_dstep;
    end

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        tdma_stepper #(.ADDR_W(ADDR_W)) u_step (
            .clk(clk), .rst_n(rst_n),
            .load(wr_start), .load_val(side_reg[g]), .load_word(wr_word),
            .adv(side_adv[g]), .mode(side_mode[g]), .unit_word(ctl_word),
            .addr_q(side_addr[g])
        );
    end

    tdma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .wr_start(wr_start), .wr_stop(wr_stop), .wr_now(wr_now),
        .wr_count(wr_count),
        .ctl_en(ctl_en), .ctl_start(ctl_start), .ctl_rpt(ctl_rpt),
        .ctl_word(ctl_word), .ctl_count(ctl_count),
        .trig_vbl(vblank_pulse), .trig_hbl(hblank_pulse), .trig_fifo(fifo_req_pulse),
        .src_addr(side_addr[0]), .dst_addr(side_addr[1]),
        .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_word(mem_word), .mem_wdata(mem_wdata),
        .cpu_stall(cpu_stall), .blk_done(blk_done),
        .src_adv(src_adv), .dst_adv(dst_adv)
    );

    // R6: word accesses on the bus are 4-byte aligned.
    a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_word) |-> (mem_addr[1:0] == 2'b00));

    // R6: halfword accesses on the bus are 2-byte aligned.
    a_r6_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_word) |-> (mem_addr[0] == 1'b0));

endmodule

// File: tb/sim_trig_dma_channel.sv
// Scoreboard bench: tasks push expected bus units, a monitor pops and compares.
module sim_trig_dma_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_addr = 2'd0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        vbl = 1'b0, hbl = 1'b0, fifo = 1'b0;
    logic        mem_req, mem_we, mem_word;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int total = 0;
    int bad = 0;
    int stall_cnt = 0;
    int s0 = 0;
    logic [31:0] last_rd = '0;

    typedef struct { logic [31:0] rd; logic [31:0] wr; logic word; } unit_t;
    unit_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    trig_dma_channel u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .vblank_pulse(vbl), .hblank_pulse(hbl), .fifo_req_pulse(fifo),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_word(mem_word), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
    endfunction

    // Zero-wait memory model: read data follows the address in the same cycle.
    assign mem_rdata = (mem_req && !mem_we) ? pat(mem_addr) : 32'hDEAD_BEEF;

    function automatic logic [31:0] mk_ctl(input bit en, input bit [1:0] st,
        input bit word, input bit rpt, input bit [1:0] ss, input bit [1:0] ds,
        input bit [15:0] n);
        return {en, 1'b0, st, 1'b0, word, rpt, ss, ds, 5'd0, n};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: count stall cycles and compare each completed unit with the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cpu_stall) stall_cnt++;
            if (mem_req && !mem_we) begin
                if (exp_q.size() == 0)
                    check(1'b0, "R7/R10 unexpected read", mem_addr, 32'h0);
                last_rd = mem_addr;
            end
            if (mem_req && mem_we && exp_q.size() != 0) begin
                unit_t e;
                e = exp_q.pop_front();
                check(last_rd == e.rd, "R2/R5/R6 read address", last_rd, e.rd);
                check(mem_addr == e.wr && mem_wdata == pat(e.rd) && mem_word == e.word,
                      "R2/R3/R4 write address/data", mem_addr, e.wr);
            end
        end
    end

    // Driver: queue the expected units of one block (modes 0 inc, 1 dec, 2 fixed).
    task automatic push_block(input logic [31:0] s, input logic [31:0] d, input int n,
                              input int sm, input int dm, input bit word);
        logic [31:0] st;
        st = word ? 32'd4 : 32'd2;
        s = s & (word ? ~32'd3 : ~32'd1);
        d = d & (word ? ~32'd3 : ~32'd1);
        for (int i = 0; i < n; i++) begin
            unit_t u;
            u.rd = s; u.wr = d; u.word = word;
            exp_q.push_back(u);
            if (sm == 0) s = s + st; else if (sm == 1) s = s - st;
            if (dm == 0) d = d + st; else if (dm == 1) d = d - st;
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = v;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        cpu_addr = a;
        #1 v = cpu_rdata;
    endtask

    task automatic mark();
        @(negedge clk);
        #1 s0 = stall_cnt;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000 - 10000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(cpu_stall == 1'b0 && mem_req == 1'b0, "R1 idle outputs", {30'd0, cpu_stall, mem_req}, 32'h0);
        for (int a = 0; a < 3; a++) begin
            reg_rd(2'(a), v);
            check(v == 32'h0, "R1 register reset", v, 32'h0);
        end

        // R2 R3 R4 R5 R12: immediate word block, both incrementing
        reg_wr(2'd0, 32'h0000_0100);
        reg_wr(2'd1, 32'h0000_0200);
        push_block(32'h100, 32'h200, 4, 0, 0, 1'b1);
        mark();
        reg_wr(2'd2, mk_ctl(1, 2'b00, 1, 0, 2'b00, 2'b00, 16'd4));
        settle(12);
        check(stall_cnt - s0 == 8, "R12 stall length 4 words", stall_cnt - s0, 8);
        check(exp_q.size() == 0, "R2 all units moved", exp_q.size(), 0);
        reg_rd(2'd2, v);
        check(v[31] == 1'b0, "R8 enable self-clear", {31'd0, v[31]}, 32'h0);

        // R3 R4 R5 R6: halfword, decrementing source, fixed destination, misaligned
        reg_wr(2'd0, 32'h0000_0303);
        reg_wr(2'd1, 32'h0000_0401);
        push_block(32'h303, 32'h401, 3, 1, 2, 1'b0);
        mark();
        reg_wr(2'd2, mk_ctl(1, 2'b00, 0, 0, 2'b01, 2'b10, 16'd3));
        settle(10);
        check(stall_cnt - s0 == 6, "R12 stall length 3 halfwords", stall_cnt - s0, 6);
        check(exp_q.size() == 0, "R3 halfword units moved", exp_q.size(), 0);

        // R4 R5 R6: word, fixed source, decrementing destination, misaligned
        reg_wr(2'd0, 32'h0000_0012);
        reg_wr(2'd1, 32'h0000_0507);
        push_block(32'h12, 32'h507, 2, 2, 1, 1'b1);
        reg_wr(2'd2, mk_ctl(1, 2'b00, 1, 0, 2'b10, 2'b01, 16'd2));
        settle(8);
        check(exp_q.size() == 0, "R6 aligned word units moved", exp_q.size(), 0);

        // R7: armed on vertical blank, other triggers ignored
        reg_wr(2'd0, 32'h0000_0800);
        reg_wr(2'd1, 32'h0000_0900);
        reg_wr(2'd2, mk_ctl(1, 2'b01, 1, 0, 2'b00, 2'b00, 16'd2));
        mark();
        @(negedge clk); hbl = 1'b1; @(negedge clk); hbl = 1'b0;
        @(negedge clk); fifo = 1'b1; @(negedge clk); fifo = 1'b0;
        settle(6);
        check(stall_cnt - s0 == 0, "R7 wrong trigger ignored", stall_cnt - s0, 0);
        push_block(32'h800, 32'h900, 2, 0, 0, 1'b1);
        mark();
        @(negedge clk); vbl = 1'b1; @(negedge clk); vbl = 1'b0;
        settle(8);
        check(stall_cnt - s0 == 4, "R7 vblank starts block", stall_cnt - s0, 4);
        check(exp_q.size() == 0, "R7 vblank units moved", exp_q.size(), 0);

        // R7: FIFO request trigger
        reg_wr(2'd0, 32'h0000_0A00);
        reg_wr(2'd1, 32'h0000_0B00);
        reg_wr(2'd2, mk_ctl(1, 2'b11, 1, 0, 2'b00, 2'b00, 16'd1));
        push_block(32'hA00, 32'hB00, 1, 0, 0, 1'b1);
        @(negedge clk); fifo = 1'b1; @(negedge clk); fifo = 1'b0;
        settle(6);
        check(exp_q.size() == 0, "R7 fifo request starts block", exp_q.size(), 0);

        // R9: repeat on horizontal blank, count reloaded, addresses continue
        reg_wr(2'd0, 32'h0000_0600);
        reg_wr(2'd1, 32'h0000_0700);
        reg_wr(2'd2, mk_ctl(1, 2'b10, 1, 1, 2'b00, 2'b00, 16'd2));
        push_block(32'h600, 32'h700, 2, 0, 0, 1'b1);
        mark();
        @(negedge clk); hbl = 1'b1; @(negedge clk); hbl = 1'b0;
        settle(8);
        check(stall_cnt - s0 == 4, "R9 first repeat block", stall_cnt - s0, 4);
        reg_rd(2'd2, v);
        check(v[31] == 1'b1, "R9 enable kept", {31'd0, v[31]}, 32'h1);
        push_block(32'h608, 32'h708, 2, 0, 0, 1'b1);
        mark();
        @(negedge clk); hbl = 1'b1; @(negedge clk); hbl = 1'b0;
        settle(8);
        check(stall_cnt - s0 == 4, "R9 second block reloads count", stall_cnt - s0, 4);
        check(exp_q.size() == 0, "R9 addresses continue", exp_q.size(), 0);

        // R10: cancel the armed repeat channel
        reg_wr(2'd2, mk_ctl(0, 2'b10, 1, 1, 2'b00, 2'b00, 16'd2));
        mark();
        @(negedge clk); hbl = 1'b1; @(negedge clk); hbl = 1'b0;
        settle(8);
        check(stall_cnt - s0 == 0, "R10 cancelled channel idle", stall_cnt - s0, 0);

        // R11: count field zero moves 65536 units
        reg_wr(2'd0, 32'h0000_0040);
        reg_wr(2'd1, 32'h0000_0080);
        push_block(32'h40, 32'h80, 65536, 2, 2, 1'b1);
        mark();
        reg_wr(2'd2, mk_ctl(1, 2'b00, 1, 0, 2'b10, 2'b10, 16'd0));
        settle(131072 + 8);
        check(stall_cnt - s0 == 131072, "R11 zero count is 65536 units", stall_cnt - s0, 131072);
        check(exp_q.size() == 0, "R11 all units moved", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule